// File: doc/BRIEF.md
# Power-Up Output Short Test Sequencer

This block guards a four-half-bridge class-D power stage during the first moments after its logic supply comes up. Before any bridge may switch, it walks the outputs through two fixed test steps: first it looks for any output tied to ground, then for any output tied to the high-voltage supply. External comparators report a per-output flag for each kind of short. The block only decides when each test step is enabled and whether the flags permit it to move on.

Each step passes only after a programmable number of consecutive clean clock cycles. If a flag from the active step appears, the block parks in a hold state. All bridges stay high-impedance and the shutdown line stays asserted for as long as the short remains. When the short clears, the interrupted step starts counting again from zero. After both steps pass, the block releases shutdown and the high-impedance holds, and raises a sticky done flag that lets the normal startup ramp proceed.

The test runs once per power-good interval. The amplifier's own reset input cannot start it again or cut it short. When the output configuration is single-ended, the test is skipped entirely.

Top module: `startup_short_seq`

## Requirements
- R1: While power-good is low, and after the synchronous flop reset, every `hiz_hold` bit is 1, `shutdown_n` is 0, `test_done` is 0, both test enables are 0 and `switch_en` is 0.
- R2: The first clock edge that sees power-good high in the idle state starts the ground step. From the next cycle onward, `gnd_test_en` is 1 and `sup_test_en` is 0. The two enables are never high together.
- R3: A step lasts exactly `step_cycles` consecutive clean cycles, with a value of 0 treated as 1. The ground step is always followed by the supply step, and the supply step by completion.
- R4: A flag from the active step moves the block to a hold state on the next edge. The hold keeps the enable of that step, all `hiz_hold` bits at 1 and `shutdown_n` at 0 for as long as any such flag stays high, without limit. The first clean edge then restarts the same step with a full count.
- R5: Only the active step's flags count. Ground flags during the supply step and supply flags during the ground step have no effect. `out_cfg` is read when the test starts, with encoding 2'b00 BTL, 2'b01 PBTL, 2'b10 SE and 2'b11 reserved. The reserved code is treated like SE.
- R6: With an SE or reserved configuration, the block goes straight from idle to done on the start edge, and neither test enable ever rises.
- R7: `shutdown_n` stays 0 until both steps have passed. In the done state, `shutdown_n` is 1, `test_done` is 1 and every `hiz_hold` bit is 0.
- R8: Done is sticky while power-good stays high. Short flags seen after completion do not restart the test.
- R9: `amp_reset_n` has no effect on the test sequence or on its timing. `switch_en` is 1 exactly when `test_done` is 1 and `amp_reset_n` is 1. A low `amp_reset_n` after completion never starts a new test.
- R10: Power-good low at any clock edge returns the block to idle on that edge. The next power-good high then runs the full test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high flop reset |
| pwr_good | input | 1 | Logic supply valid |
| amp_reset_n | input | 1 | Amplifier reset request, active low |
| out_cfg | input | 2 | Output configuration code |
| step_cycles | input | CNT_W | Clean cycles required per test step |
| gnd_short | input | NUM_OUT | Per-output short-to-ground comparator flags |
| sup_short | input | NUM_OUT | Per-output short-to-supply comparator flags |
| hiz_hold | output | NUM_OUT | Per-bridge high-impedance hold |
| gnd_test_en | output | 1 | Ground-short test step active |
| sup_test_en | output | 1 | Supply-short test step active |
| shutdown_n | output | 1 | Shutdown, active low |
| test_done | output | 1 | Test passed or skipped; startup may proceed |
| switch_en | output | 1 | Bridges may switch |

## Verification
The bench builds the block with four outputs and a 4-bit step counter. It drives `step_cycles` at 5 for most scenarios and at 0 for the boundary case. This keeps each step short enough that the exact cycle of every transition can be predicted. It also makes it practical to hold a short for three full step lengths, to show the wait has no timeout, and to interleave flags from the inactive step. The same settings cover a power-good drop in mid-test, both skip codes, and reset toggles before and after completion.

// File: rtl/sst_pkg.sv
package sst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_TEST_GND    = 3'd1,
        ST_TEST_SUPPLY = 3'd2,
        ST_HOLD_SHORT  = 3'd3,
        ST_DONE        = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        CFG_BTL  = 2'b00,
        CFG_PBTL = 2'b01,
        CFG_SE   = 2'b10,
        CFG_RSVD = 2'b11
    } out_cfg_e;

    typedef enum logic {
        PH_GND = 1'b0,
        PH_SUP = 1'b1
    } test_phase_e;

    typedef struct packed {
        logic hiz;
        logic gnd_en;
        logic sup_en;
        logic shutdown_n;
        logic done;
    } seq_out_t;

    function automatic logic cfg_needs_test(input logic [1:0] cfg);
        return (cfg == CFG_BTL) || (cfg == CFG_PBTL);
    endfunction

    function automatic seq_out_t decode_outputs(input seq_state_e st, input test_phase_e ph);
        seq_out_t o;
        o.hiz        = 1'b1;
        o.gnd_en     = 1'b0;
        o.sup_en     = 1'b0;
        o.shutdown_n = 1'b0;
        o.done       = 1'b0;
        case (st)
            ST_TEST_GND:    o.gnd_en = 1'b1;
            ST_TEST_SUPPLY: o.sup_en = 1'b1;
            ST_HOLD_SHORT: begin
                o.gnd_en = (ph == PH_GND);
                o.sup_en = (ph == PH_SUP);
            end
            ST_DONE: begin
                o.hiz        = 1'b0;
                o.shutdown_n = 1'b1;
                o.done       = 1'b1;
            end
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/sst_flag_merge.sv
module sst_flag_merge
    import sst_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input  logic [NUM_OUT-1:0] gnd_flags,
    input  logic [NUM_OUT-1:0] sup_flags,
    input  test_phase_e        phase,
    output logic               active_hit
);
    logic [NUM_OUT-1:0] lane_hit;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        assign lane_hit[i] = (phase == PH_SUP) ? sup_flags[i] : gnd_flags[i];
    end

    assign active_hit = |lane_hit;
endmodule

// File: rtl/sst_step_timer.sv
module sst_step_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] last_idx;

    assign last_idx = (limit == '0) ? '0 : limit - CNT_W'(1);
    assign expire   = (count_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sst_seq_fsm.sv
module sst_seq_fsm
    import sst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_good,
    input  logic [1:0]  cfg,
    input  logic        active_hit,
    input  logic        expire,
    output seq_state_e  state,
    output test_phase_e phase,
    output logic        timer_clear,
    output logic        timer_adv
);
    seq_state_e  state_q, state_d;
    test_phase_e phase_q, phase_d;

    always_comb begin
        state_d     = state_q;
        phase_d     = phase_q;
        timer_clear = 1'b0;
        timer_adv   = 1'b0;
        if (!pwr_good) begin
            state_d     = ST_IDLE;
            phase_d     = PH_GND;
            timer_clear = 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    timer_clear = 1'b1;
                    phase_d     = PH_GND;
                    state_d     = cfg_needs_test(cfg) ? ST_TEST_GND : ST_DONE;
                end
                ST_TEST_GND, ST_TEST_SUPPLY: begin
                    if (active_hit) begin
                        state_d     = ST_HOLD_SHORT;
                        timer_clear = 1'b1;
                    end else if (expire) begin
                        timer_clear = 1'b1;
                        if (phase_q == PH_GND) begin
                            state_d = ST_TEST_SUPPLY;
                            phase_d = PH_SUP;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end else begin
                        timer_adv = 1'b1;
                    end
                end
                ST_HOLD_SHORT: begin
                    timer_clear = 1'b1;
                    if (!active_hit) begin
                        state_d = (phase_q == PH_GND) ? ST_TEST_GND : ST_TEST_SUPPLY;
                    end
                end
                ST_DONE: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_GND;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    assign state = state_q;
    assign phase = phase_q;
endmodule

// File: rtl/startup_short_seq.sv
module startup_short_seq
    import sst_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_good,
    input  logic               amp_reset_n,
    input  logic [1:0]         out_cfg,
    input  logic [CNT_W-1:0]   step_cycles,
    input  logic [NUM_OUT-1:0] gnd_short,
    input  logic [NUM_OUT-1:0] sup_short,
    output logic [NUM_OUT-1:0] hiz_hold,
    output logic               gnd_test_en,
    output logic               sup_test_en,
    output logic               shutdown_n,
    output logic               test_done,
    output logic               switch_en
);
    seq_state_e  state;
    test_phase_e phase;
    logic        active_hit;
    logic        expire;
    logic        timer_clear;
    logic        timer_adv;
    seq_out_t    outs;

    sst_flag_merge #(.NUM_OUT(NUM_OUT)) u_merge (
        .gnd_flags  (gnd_short),
        .sup_flags  (sup_short),
        .phase      (phase),
        .active_hit (active_hit)
    );

    sst_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (timer_clear),
        .advance (timer_adv),
        .limit   (step_cycles),
        .expire  (expire)
    );

    sst_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pwr_good    (pwr_good),
        .cfg         (out_cfg),
        .active_hit  (active_hit),
        .expire      (expire),
        .state       (state),
        .phase       (phase),
        .timer_clear (timer_clear),
        .timer_adv   (timer_adv)
    );

    assign outs        = decode_outputs(state, phase);
    assign hiz_hold    = {NUM_OUT{outs.hiz}};
    assign gnd_test_en = outs.gnd_en;
    assign sup_test_en = outs.sup_en;
    assign shutdown_n  = outs.shutdown_n;
    assign test_done   = outs.done;
    assign switch_en   = outs.done & amp_reset_n;
endmodule

// File: rtl/startup_short_seq_chk.sv
module startup_short_seq_chk #(
    parameter int NUM_OUT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               pwr_good,
    input logic               amp_reset_n,
    input logic [NUM_OUT-1:0] hiz_hold,
    input logic               gnd_test_en,
    input logic               sup_test_en,
    input logic               shutdown_n,
    input logic               test_done,
    input logic               switch_en
);
    assert_enables_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(gnd_test_en && sup_test_en));

    assert_supply_follows_ground_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sup_test_en) |-> $past(gnd_test_en));

    assert_hiz_until_done_R4: assert property (@(posedge clk) disable iff (rst)
        !test_done |-> (&hiz_hold));

    assert_shutdown_released_only_done_R7: assert property (@(posedge clk) disable iff (rst)
        shutdown_n |-> test_done);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (test_done && pwr_good) |=> test_done);

    assert_reset_blocks_switch_R9: assert property (@(posedge clk) disable iff (rst)
        !amp_reset_n |-> !switch_en);

    assert_pg_loss_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (!test_done && !gnd_test_en && !sup_test_en));
endmodule

bind startup_short_seq startup_short_seq_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_good    (pwr_good),
    .amp_reset_n (amp_reset_n),
    .hiz_hold    (hiz_hold),
    .gnd_test_en (gnd_test_en),
    .sup_test_en (sup_test_en),
    .shutdown_n  (shutdown_n),
    .test_done   (test_done),
    .switch_en   (switch_en)
);

// File: tb/tb_startup_short_seq.sv
`timescale 1ns/1ps
module tb_startup_short_seq;
    localparam int NUM_OUT = 4;
    localparam int CNT_W   = 4;
    localparam int N       = 5;

    // {hiz all ones, hiz any one, gnd_en, sup_en, shutdown_n, done, switch_en}
    localparam logic [6:0] P_IDLE = 7'b11_0_0_0_0_0;
    localparam logic [6:0] P_GND  = 7'b11_1_0_0_0_0;
    localparam logic [6:0] P_SUP  = 7'b11_0_1_0_0_0;
    localparam logic [6:0] P_DONE = 7'b00_0_0_1_1_1;
    localparam logic [6:0] P_DRST = 7'b00_0_0_1_1_0;

    logic clk = 1'b0;
    logic rst;
    logic pwr_good;
    logic amp_reset_n;
    logic [1:0] out_cfg;
    logic [CNT_W-1:0] step_cycles;
    logic [NUM_OUT-1:0] gnd_short;
    logic [NUM_OUT-1:0] sup_short;
    logic [NUM_OUT-1:0] hiz_hold;
    logic gnd_test_en, sup_test_en, shutdown_n, test_done, switch_en;

    always #2.5 clk = ~clk;

    startup_short_seq #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .amp_reset_n(amp_reset_n),
        .out_cfg(out_cfg), .step_cycles(step_cycles),
        .gnd_short(gnd_short), .sup_short(sup_short),
        .hiz_hold(hiz_hold), .gnd_test_en(gnd_test_en), .sup_test_en(sup_test_en),
        .shutdown_n(shutdown_n), .test_done(test_done), .switch_en(switch_en)
    );

    typedef struct {
        int         due;
        logic [6:0] val;
        string      req;
    } exp_item_t;

    exp_item_t sb_q[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_span(input int from, input int upto, input logic [6:0] v, input string req);
        for (int c = from; c <= upto; c++) begin
            exp_item_t it;
            it.due = c; it.val = v; it.req = req;
            sb_q.push_back(it);
        end
    endtask

    task automatic goto(input int t);
        while (cyc < t) @(negedge clk);
        #0.5;
    endtask

    // monitor: pops every expectation due in this cycle and compares
    always @(negedge clk) begin
        logic [6:0] act;
        act = {&hiz_hold, |hiz_hold, gnd_test_en, sup_test_en, shutdown_n, test_done, switch_en};
        for (int k = sb_q.size() - 1; k >= 0; k--) begin
            if (sb_q[k].due == cyc) begin
                total++;
                if (act !== sb_q[k].val) begin
                    bad++;
                    $display("FAIL %s cycle %0d: actual=%b expected=%b", sb_q[k].req, cyc, act, sb_q[k].val);
                end
                sb_q.delete(k);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            foreach (sb_q[k]) begin
                total++; bad++;
                $display("FAIL %s cycle %0d: actual=unchecked expected=%b", sb_q[k].req, sb_q[k].due, sb_q[k].val);
            end
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        while (cyc < 20000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
        finish_run();
    end

    initial begin
        int b, b2;
        rst = 1'b1; pwr_good = 1'b0; amp_reset_n = 1'b1; out_cfg = 2'b00;
        step_cycles = CNT_W'(N); gnd_short = '0; sup_short = '0;
        goto(3);
        rst = 1'b0;
        b = cyc;
        expect_span(b + 1, b + 3, P_IDLE, "R1");
        goto(b + 4);

        // clean BTL run
        b = cyc; pwr_good = 1'b1;
        expect_span(b + 1, b + N, P_GND, "R2");
        expect_span(b + N + 1, b + 2*N, P_SUP, "R3");
        expect_span(b + 2*N + 1, b + 2*N + 3, P_DONE, "R7");
        goto(b + 2*N + 4);

        // flags and reset after completion
        b = cyc; gnd_short = '1; sup_short = '1; amp_reset_n = 1'b0;
        expect_span(b + 1, b + 3, P_DRST, "R9");
        expect_span(b + 4, b + 5, P_DONE, "R8");
        goto(b + 3);
        gnd_short = '0; sup_short = '0; amp_reset_n = 1'b1;
        goto(b + 6);

        b = cyc; pwr_good = 1'b0;
        expect_span(b + 1, b + 2, P_IDLE, "R10");
        goto(b + 3);

        // ground short with long hold, reset toggles, inactive-step flags
        b = cyc; pwr_good = 1'b1;
        expect_span(b + 1, b + 23, P_GND, "R4");
        expect_span(b + 24, b + 28, P_SUP, "R5");
        expect_span(b + 29, b + 30, P_DONE, "R3");
        goto(b + 3);  gnd_short = 4'b0100;
        goto(b + 5);  amp_reset_n = 1'b0;
        goto(b + 10); amp_reset_n = 1'b1;
        goto(b + 18); gnd_short = '0;
        goto(b + 20); sup_short = 4'b1001;
        goto(b + 23); sup_short = '0;
        goto(b + 24); gnd_short = '1;
        goto(b + 27); gnd_short = '0;
        goto(b + 31);
        b = cyc; pwr_good = 1'b0;
        expect_span(b + 1, b + 1, P_IDLE, "R10");
        goto(b + 2);

        // supply short in the supply step
        b = cyc; pwr_good = 1'b1;
        expect_span(b + 1, b + N, P_GND, "R3");
        expect_span(b + N + 1, b + 17, P_SUP, "R4");
        expect_span(b + 18, b + 19, P_DONE, "R7");
        goto(b + 7);  sup_short = 4'b0010;
        goto(b + 12); sup_short = '0;
        goto(b + 20);
        pwr_good = 1'b0;
        goto(cyc + 2);

        // skipped configurations
        out_cfg = 2'b10;
        b = cyc; pwr_good = 1'b1;
        expect_span(b + 1, b + 3, P_DONE, "R6");
        goto(b + 4);
        pwr_good = 1'b0;
        goto(cyc + 2);
        out_cfg = 2'b11;
        b = cyc; pwr_good = 1'b1;
        expect_span(b + 1, b + 3, P_DONE, "R5");
        goto(b + 4);
        pwr_good = 1'b0;
        goto(cyc + 2);

        // power-good loss mid-test and re-arm, PBTL
        out_cfg = 2'b01;
        b = cyc; pwr_good = 1'b1;
        expect_span(b + 1, b + 3, P_GND, "R2");
        expect_span(b + 4, b + 6, P_IDLE, "R10");
        goto(b + 3); pwr_good = 1'b0;
        goto(b + 7);
        b2 = cyc; pwr_good = 1'b1;
        expect_span(b2 + 1, b2 + N, P_GND, "R10");
        expect_span(b2 + N + 1, b2 + 2*N, P_SUP, "R3");
        expect_span(b2 + 2*N + 1, b2 + 2*N + 1, P_DONE, "R7");
        goto(b2 + 2*N + 2);
        pwr_good = 1'b0;
        goto(cyc + 2);

        // zero step count behaves as one cycle
        out_cfg = 2'b00; step_cycles = '0;
        b = cyc; pwr_good = 1'b1;
        expect_span(b + 1, b + 1, P_GND, "R3");
        expect_span(b + 2, b + 2, P_SUP, "R3");
        expect_span(b + 3, b + 4, P_DONE, "R3");
        goto(b + 5);
        goto(cyc + 1);
        finish_run();
    end
endmodule